// File: doc/BRIEF.md
# Bark-and-Bite Watchdog Counter

This block is a 32-bit up-counting watchdog with two separate limits. The lower limit, the bark, raises a sticky interrupt, a mirrored non-maskable interrupt line and a sticky wakeup request. The higher limit, the bite, drives a reset request for as long as the condition lasts. Software keeps the system alive by writing zero to the count. It can also load any other value into the count. Registers are reached through plain one-cycle write strobes that share a single data bus.

A three-state machine governs counting. The states are:
- `ST_OFF`: counting is disabled.
- `ST_RUN`: the count advances once per clock.
- `ST_HOLD`: the count is frozen.

The transitions are:
- `ARM`: `ST_OFF` to `ST_RUN`, when the enable bit is set and no pause applies.
- `DISARM`: any state to `ST_OFF`, when the enable bit is clear.
- `PAUSE`: `ST_RUN` to `ST_HOLD`, or `ST_OFF` to `ST_HOLD` when the block is enabled while a pause applies. A pause applies when the escalation input is high, or when the sleep input is high and the sleep-hold bit is set.
- `RESUME`: `ST_HOLD` to `ST_RUN`, when the pause is removed.

A one-way lock, once cleared, freezes the control bits and both limits until reset.

Top module: `barkbite_wdog`

## Requirements
- R1: After reset, the outputs and internal values are as follows:
  - `count_o` is 0.
  - `intr_bark_o`, `nmi_bark_o`, `wake_req_o` and `rst_req_o` are 0.
  - `lock_o` is 1.
  - Counting is disabled, and both limits are all-ones.
- R2: A write to the control register with `ctl_run_i`=1 enables counting. The state becomes `ST_RUN` one edge after the enable bit is stored. Each edge in `ST_RUN` adds one to the count. The first increment therefore lands on the second edge after the write edge.
- R3: The count saturates at 0xFFFFFFFF and never wraps.
- R4: `intr_bark_o` is set at an edge where the state is `ST_RUN` and the count before that edge is greater than or equal to the bark limit. Once set, it stays high until an `intr_clr_i` strobe. If a clear strobe and a new bark fall on the same edge, the bark wins.
- R5: `nmi_bark_o` always carries the same value as `intr_bark_o`.
- R6: A bark also sets `wake_req_o`. It stays high until a `cause_clr_i` strobe, and an interrupt clear does not affect it.
- R7: `rst_req_o` is a registered copy of the bite condition at each edge. The bite condition is: state `ST_RUN` and count greater than or equal to the bite limit. The output is not latched, so it falls one edge after the condition stops holding.
- R8: A `cnt_we_i` strobe loads `wdata_i` into the count and takes priority over the increment. Writing 0 pets the watchdog.
- R9: With the sleep-hold bit set, `sleep_i`=1 moves the state to `ST_HOLD` at the next edge and the count stays frozen. With the bit clear, `sleep_i` has no effect.
- R10: `esc_i`=1 always moves the state to `ST_HOLD` at the next edge, and the count stays frozen while it is held.
- R11: While `lock_o`=0, the block ignores writes to the control register (`ctl_we_i`), the bark limit (`bark_we_i`) and the bite limit (`bite_we_i`). Count writes are still accepted.
- R12: An `lock_clr_i` strobe drives `lock_o` to 0. Only reset can return it to 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wdata_i | input | 32 | Shared write data for the count and limit writes |
| ctl_we_i | input | 1 | Control write strobe |
| ctl_run_i | input | 1 | Control data: enable counting |
| ctl_sleep_hold_i | input | 1 | Control data: pause while the sleep input is high |
| bark_we_i | input | 1 | Bark limit write strobe |
| bite_we_i | input | 1 | Bite limit write strobe |
| cnt_we_i | input | 1 | Count write strobe (pet) |
| lock_clr_i | input | 1 | Clears the configuration lock |
| intr_clr_i | input | 1 | Clears the bark interrupt |
| cause_clr_i | input | 1 | Clears the wakeup request |
| sleep_i | input | 1 | Sleep indication |
| esc_i | input | 1 | Escalation active, pauses counting |
| count_o | output | 32 | Current count |
| lock_o | output | 1 | 1 while configuration writes are allowed |
| intr_bark_o | output | 1 | Sticky bark interrupt |
| nmi_bark_o | output | 1 | Mirror of the bark interrupt |
| wake_req_o | output | 1 | Sticky wakeup request |
| rst_req_o | output | 1 | Bite reset request |

## Verification
A control write reaches the count only on the second edge after its own edge. A pause or resume changes the state one edge after the input moves. A pet changes the count one edge after the strobe, while the reset request follows the old count for that one extra edge. The bark flags and the reset request are registered from the count value before the edge, so they first read high in the same sample in which the count reads one above the limit. The bench drives inputs on falling edges and samples on falling edges. It steps until the count equals a limit, checks that the flag is still low, then steps once more and checks that it has risen. Each expected value is derived from these edge counts.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
    typedef enum logic [1:0] {
        ST_OFF  = 2'd0,
        ST_RUN  = 2'd1,
        ST_HOLD = 2'd2
    } wd_state_e;

    localparam int unsigned LIM_N    = 2;
    localparam int unsigned LIM_BARK = 0;
    localparam int unsigned LIM_BITE = 1;
endpackage

// File: rtl/wdog_fsm.sv
module wdog_fsm
    import wdog_pkg::*;
(
    input  logic      clk_i,
    input  logic      rst_ni,
    input  logic      run_en_i,
    input  logic      sleep_hold_i,
    input  logic      sleep_i,
    input  logic      esc_i,
    output wd_state_e state_o,
    output logic      tick_o
);
    wd_state_e state_q, state_d;
    logic      pause;

    assign pause = esc_i || (sleep_hold_i && sleep_i);

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) state_q <= ST_OFF;
        else         state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_OFF: begin
                if (run_en_i) state_d = pause ? ST_HOLD : ST_RUN;   // ARM / PAUSE
            end
            ST_RUN: begin
                if (!run_en_i)  state_d = ST_OFF;                   // DISARM
                else if (pause) state_d = ST_HOLD;                  // PAUSE
            end
            ST_HOLD: begin
                if (!run_en_i)  state_d = ST_OFF;                   // DISARM
                else if (!pause) state_d = ST_RUN;                  // RESUME
            end
            default: state_d = ST_OFF;
        endcase
    end

    always_comb begin
        tick_o = 1'b0;
        unique case (state_q)
            ST_OFF:  tick_o = 1'b0;
            ST_RUN:  tick_o = 1'b1;
            ST_HOLD: tick_o = 1'b0;
            default: tick_o = 1'b0;
        endcase
    end

    assign state_o = state_q;

    // R10: escalation forces the hold state on the following edge
    p_esc_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (esc_i && run_en_i) |=> (state_q == ST_HOLD));
endmodule

// File: rtl/wdog_count.sv
module wdog_count #(
    parameter int unsigned CNT_W = 32
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             tick_i,
    input  logic             load_i,
    input  logic [CNT_W-1:0] load_val_i,
    output logic [CNT_W-1:0] count_o
);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)                          cnt_q <= '0;
        else if (load_i)                      cnt_q <= load_val_i;
        else if (tick_i && cnt_q != CNT_MAX)  cnt_q <= cnt_q + 1'b1;
    end

    assign count_o = cnt_q;

    // R3: a full count stays full unless reloaded
    p_no_wrap_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (cnt_q == CNT_MAX && !load_i) |=> (cnt_q == CNT_MAX));
    // R9/R10: a frozen state leaves the count unchanged
    p_hold_freeze_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!tick_i && !load_i) |=> $stable(cnt_q));
    // R8: load has priority
    p_load_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        load_i |=> (cnt_q == $past(load_val_i)));
endmodule

// File: rtl/wdog_cfg.sv
module wdog_cfg
    import wdog_pkg::*;
#(
    parameter int unsigned CNT_W = 32
) (
    input  logic                        clk_i,
    input  logic                        rst_ni,
    input  logic [CNT_W-1:0]            wdata_i,
    input  logic                        ctl_we_i,
    input  logic                        ctl_run_i,
    input  logic                        ctl_sleep_hold_i,
    input  logic [LIM_N-1:0]            lim_we_i,
    input  logic                        lock_clr_i,
    output logic                        run_en_o,
    output logic                        sleep_hold_o,
    output logic [LIM_N-1:0][CNT_W-1:0] lim_o,
    output logic                        lock_o
);
    logic run_q, hold_q, lock_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            run_q  <= 1'b0;
            hold_q <= 1'b0;
        end else if (ctl_we_i && lock_q) begin
            run_q  <= ctl_run_i;
            hold_q <= ctl_sleep_hold_i;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)         lock_q <= 1'b1;
        else if (lock_clr_i) lock_q <= 1'b0;
    end

    for (genvar g = 0; g < LIM_N; g++) begin : g_lim
        logic [CNT_W-1:0] lim_q;
        always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni)                     lim_q <= '1;
            else if (lim_we_i[g] && lock_q)  lim_q <= wdata_i;
        end
        assign lim_o[g] = lim_q;
    end

    assign run_en_o     = run_q;
    assign sleep_hold_o = hold_q;
    assign lock_o       = lock_q;

    // R12: once cleared the lock stays cleared
    p_lock_oneway_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !lock_q |=> !lock_q);
    // R11: locked control ignores writes
    p_locked_ctl_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!lock_q && ctl_we_i) |=> ($stable(run_q) && $stable(hold_q)));
endmodule

// File: rtl/wdog_flags.sv
module wdog_flags
    import wdog_pkg::*;
#(
    parameter int unsigned CNT_W = 32
) (
    input  logic                        clk_i,
    input  logic                        rst_ni,
    input  logic                        tick_i,
    input  logic [CNT_W-1:0]            count_i,
    input  logic [LIM_N-1:0][CNT_W-1:0] lim_i,
    input  logic                        intr_clr_i,
    input  logic                        cause_clr_i,
    output logic                        intr_o,
    output logic                        wake_o,
    output logic                        rst_req_o
);
    logic [LIM_N-1:0] hit;
    logic intr_q, wake_q, rst_q;

    for (genvar g = 0; g < LIM_N; g++) begin : g_cmp
        assign hit[g] = tick_i && (count_i >= lim_i[g]);
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            intr_q <= 1'b0;
            wake_q <= 1'b0;
            rst_q  <= 1'b0;
        end else begin
            intr_q <= (intr_q && !intr_clr_i)  || hit[LIM_BARK];
            wake_q <= (wake_q && !cause_clr_i) || hit[LIM_BARK];
            rst_q  <= hit[LIM_BITE];
        end
    end

    assign intr_o    = intr_q;
    assign wake_o    = wake_q;
    assign rst_req_o = rst_q;

    // R6: wakeup request is sticky until its own clear
    p_wake_sticky_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (wake_q && !cause_clr_i) |=> wake_q);
    // R4: bark interrupt is sticky until cleared
    p_intr_sticky_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (intr_q && !intr_clr_i) |=> intr_q);
    // R7: no reset request without a running counter
    p_rst_needs_run_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !tick_i |=> !rst_q);
endmodule

// File: rtl/barkbite_wdog.sv
module barkbite_wdog
    import wdog_pkg::*;
#(
    parameter int unsigned CNT_W = 32
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic [CNT_W-1:0] wdata_i,
    input  logic             ctl_we_i,
    input  logic             ctl_run_i,
    input  logic             ctl_sleep_hold_i,
    input  logic             bark_we_i,
    input  logic             bite_we_i,
    input  logic             cnt_we_i,
    input  logic             lock_clr_i,
    input  logic             intr_clr_i,
    input  logic             cause_clr_i,
    input  logic             sleep_i,
    input  logic             esc_i,
    output logic [CNT_W-1:0] count_o,
    output logic             lock_o,
    output logic             intr_bark_o,
    output logic             nmi_bark_o,
    output logic             wake_req_o,
    output logic             rst_req_o
);
    logic                        run_en, sleep_hold, tick, intr;
    logic [LIM_N-1:0]            lim_we;
    logic [LIM_N-1:0][CNT_W-1:0] lim;
    logic [CNT_W-1:0]            count;
    wd_state_e                   state;

    assign lim_we[LIM_BARK] = bark_we_i;
    assign lim_we[LIM_BITE] = bite_we_i;

    wdog_cfg #(.CNT_W(CNT_W)) u_cfg (
        .clk_i, .rst_ni, .wdata_i, .ctl_we_i, .ctl_run_i, .ctl_sleep_hold_i,
        .lim_we_i(lim_we), .lock_clr_i, .run_en_o(run_en),
        .sleep_hold_o(sleep_hold), .lim_o(lim), .lock_o(lock_o)
    );

    wdog_fsm u_fsm (
        .clk_i, .rst_ni, .run_en_i(run_en), .sleep_hold_i(sleep_hold),
        .sleep_i, .esc_i, .state_o(state), .tick_o(tick)
    );

    wdog_count #(.CNT_W(CNT_W)) u_cnt (
        .clk_i, .rst_ni, .tick_i(tick), .load_i(cnt_we_i),
        .load_val_i(wdata_i), .count_o(count)
    );

    wdog_flags #(.CNT_W(CNT_W)) u_flags (
        .clk_i, .rst_ni, .tick_i(tick), .count_i(count), .lim_i(lim),
        .intr_clr_i, .cause_clr_i, .intr_o(intr), .wake_o(wake_req_o),
        .rst_req_o(rst_req_o)
    );

    assign count_o     = count;
    assign intr_bark_o = intr;
    assign nmi_bark_o  = intr;

    // R2: in the run state an unloaded, unsaturated count advances by one
    p_step_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (state == ST_RUN && !cnt_we_i && count != {CNT_W{1'b1}})
        |=> (count == $past(count) + 1'b1));
    // R4: a bark sets the interrupt even against a clear
    p_bark_sets_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (state == ST_RUN && count >= lim[LIM_BARK]) |=> intr_bark_o);
endmodule

// File: tb/sim_barkbite_wdog.sv
module sim_barkbite_wdog;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] wdata = '0;
    logic ctl_we = 0, ctl_run = 0, ctl_hold = 0, bark_we = 0, bite_we = 0;
    logic cnt_we = 0, lock_clr = 0, intr_clr = 0, cause_clr = 0, sleep = 0, esc = 0;
    logic [31:0] count;
    logic        lock, intr, nmi, wake, rstreq;
    int          n_run = 0, n_fail = 0;
    bit          done = 0;

    always #2 clk = ~clk;

    barkbite_wdog u0 (
        .clk_i(clk), .rst_ni(rst_n), .wdata_i(wdata), .ctl_we_i(ctl_we),
        .ctl_run_i(ctl_run), .ctl_sleep_hold_i(ctl_hold), .bark_we_i(bark_we),
        .bite_we_i(bite_we), .cnt_we_i(cnt_we), .lock_clr_i(lock_clr),
        .intr_clr_i(intr_clr), .cause_clr_i(cause_clr), .sleep_i(sleep),
        .esc_i(esc), .count_o(count), .lock_o(lock), .intr_bark_o(intr),
        .nmi_bark_o(nmi), .wake_req_o(wake), .rst_req_o(rstreq)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    task automatic step(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic wr_ctl(input logic run, input logic hold);
        ctl_we = 1; ctl_run = run; ctl_hold = hold; step(1); ctl_we = 0;
    endtask
    task automatic wr_bark(input logic [31:0] v);
        bark_we = 1; wdata = v; step(1); bark_we = 0;
    endtask
    task automatic wr_bite(input logic [31:0] v);
        bite_we = 1; wdata = v; step(1); bite_we = 0;
    endtask
    task automatic pet(input logic [31:0] v);
        cnt_we = 1; wdata = v; step(1); cnt_we = 0;
    endtask
    task automatic clr_all();
        intr_clr = 1; cause_clr = 1; step(1); intr_clr = 0; cause_clr = 0;
    endtask

    task automatic t_reset();
        rst_n = 0; step(2); rst_n = 1; step(1);
        chk("R1 count", count, 0);
        chk("R1 intr", {31'd0, intr}, 0);
        chk("R1 nmi", {31'd0, nmi}, 0);
        chk("R1 wake", {31'd0, wake}, 0);
        chk("R1 rstreq", {31'd0, rstreq}, 0);
        chk("R1 lock", {31'd0, lock}, 1);
        step(3);
        chk("R1 disabled count", count, 0);
    endtask

    task automatic t_enable();
        wr_bark(100); wr_bite(200);
        wr_ctl(1, 0);
        step(5);
        chk("R2 count after enable", count, 4);
    endtask

    task automatic t_bark();
        while (count != 100) step(1);
        chk("R4 intr below", {31'd0, intr}, 0);
        step(1);
        chk("R4 count", count, 101);
        chk("R4 intr set", {31'd0, intr}, 1);
        chk("R5 nmi mirror", {31'd0, nmi}, 1);
        chk("R6 wake set", {31'd0, wake}, 1);
        chk("R7 no bite yet", {31'd0, rstreq}, 0);
    endtask

    task automatic t_bite();
        while (count != 200) step(1);
        chk("R7 rst low at limit", {31'd0, rstreq}, 0);
        step(1);
        chk("R7 rst high", {31'd0, rstreq}, 1);
        pet(0);
        chk("R8 pet count", count, 0);
        chk("R7 rst one extra edge", {31'd0, rstreq}, 1);
        step(1);
        chk("R7 rst released", {31'd0, rstreq}, 0);
        chk("R4 intr sticky", {31'd0, intr}, 1);
    endtask

    task automatic t_clear();
        intr_clr = 1; step(1); intr_clr = 0;
        chk("R4 intr cleared", {31'd0, intr}, 0);
        chk("R5 nmi cleared", {31'd0, nmi}, 0);
        chk("R6 wake kept", {31'd0, wake}, 1);
        cause_clr = 1; step(1); cause_clr = 0;
        chk("R6 wake cleared", {31'd0, wake}, 0);
        pet(150); step(1);
        intr_clr = 1; step(1); intr_clr = 0;
        chk("R4 set wins over clear", {31'd0, intr}, 1);
        pet(0); clr_all();
        chk("R4 intr clean", {31'd0, intr}, 0);
    endtask

    task automatic t_sleep();
        logic [31:0] v;
        sleep = 1; v = count; step(3);
        chk("R9 sleep ignored without hold bit", count, v + 3);
        wr_ctl(1, 1); step(1);
        v = count; step(4);
        chk("R9 held in sleep", count, v);
        sleep = 0; step(2);
        chk("R9 resumed", count, v + 1);
    endtask

    task automatic t_esc();
        logic [31:0] v;
        wr_ctl(1, 0);
        esc = 1; step(1);
        v = count; step(4);
        chk("R10 held in escalation", count, v);
        esc = 0; step(2);
        chk("R10 resumed", count, v + 1);
    endtask

    task automatic t_sat();
        pet(32'hFFFF_FFFE);
        chk("R8 load", count, 32'hFFFF_FFFE);
        step(1);
        chk("R3 reach max", count, 32'hFFFF_FFFF);
        step(2);
        chk("R3 saturate", count, 32'hFFFF_FFFF);
        pet(0); clr_all();
    endtask

    task automatic t_lock();
        lock_clr = 1; step(1); lock_clr = 0;
        chk("R12 lock cleared", {31'd0, lock}, 0);
        wr_ctl(0, 0);
        wr_bite(5);
        pet(0); step(10);
        chk("R11 ctl write ignored, still counting", count, 10);
        chk("R11 bite limit write ignored", {31'd0, rstreq}, 0);
        step(5);
        chk("R12 lock stays cleared", {31'd0, lock}, 0);
        t_reset();
        chk("R12 reset restores lock", {31'd0, lock}, 1);
    endtask

    initial begin
        step(1);
        t_reset();
        t_enable();
        t_bark();
        t_bite();
        t_clear();
        t_sleep();
        t_esc();
        t_sat();
        t_lock();
        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        #(200000 * 4);
        if (!done) begin
            n_run++; n_fail++;
            $display("FAIL watchdog: got hung expected completion");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule